// File: doc/BRIEF.md
# Multichannel Parallel ADC Sequencer

This block runs an 8-bit sampling converter that has a byte-wide parallel output and an input multiplexer of up to eight channels. It repeatedly pulses an active-low convert-start line and waits for the converter's active-low end-of-conversion input. After that input arrives, it runs a chip-select and read cycle and captures the data byte. The captured byte goes out on a valid/ready stream, tagged with the channel it was converted from.

The multiplexer address is loaded by the converter when read goes low, so the address driven during each read selects the channel for the *next* conversion. The sequencer therefore keeps its address output one step ahead of the data it delivers. Channels are chosen by an enable mask and visited in ascending order with wrap-around.

A mode input decides what happens to the start line at the end of a conversion. In normal mode the start line is back high before the conversion ends, so the converter stays powered. In power-down mode the start line is held low through the end of conversion, so the converter sleeps between samples.

Top module: `mux_adc_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, `conv_n`, `cs_n` and `rd_n` are high, `addr` is 0, and `smp_valid` and `timeout_err` are low.
- R2: When `enable` is high and `chan_mask` is nonzero, `conv_n` falls. In normal mode (`pd_mode`=0) it stays low for exactly CONV_LOW_CYC cycles and is then high.
- R3: In power-down mode (`pd_mode`=1), `conv_n` stays low until the edge on which `eoc_n` is sampled low. It rises on that same edge, the edge on which `cs_n` falls.
- R4: On the clock edge where `eoc_n` is sampled low while waiting, `cs_n` falls and `addr` changes to the next enabled channel. `rd_n` falls SETUP_CYC cycles later and stays low for READ_CYC cycles. `rd_n` and `cs_n` then rise together.
- R5: On the edge where `rd_n` rises, `smp_data` takes the value of `bus_in` sampled at that edge, and `smp_valid` rises. `smp_chan` carries the channel that was converted, not the one just addressed.
- R6: The first conversion after reset or after idling uses channel 0. Each later conversion uses the next channel, in ascending order modulo NUM_CH, whose bit in `chan_mask` is 1. If no other bit is set, the same channel repeats.
- R7: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_data` and `smp_chan` hold. `conv_n` never falls while a sample is waiting.
- R8: Two falling edges of `conv_n` are at least MIN_PERIOD_CYC cycles apart.
- R9: If `eoc_n` is not sampled low within TIMEOUT_CYC cycles after the wait begins, `timeout_err` goes high and stays high until reset. `conv_n` returns high and the block goes idle.
- R10: With `enable` low or `chan_mask` all zero, `conv_n` never falls.
- R11: `rd_n` is low only while `cs_n` is low, and `addr` does not change while `rd_n` is low or on the edge where it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request |
| chan_mask | input | NUM_CH | One bit per channel to visit |
| pd_mode | input | 1 | 1: hold start low through end of conversion (sleep between samples) |
| conv_n | output | 1 | Active-low convert-start to the converter |
| eoc_n | input | 1 | Active-low end-of-conversion from the converter |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| addr | output | CW | Multiplexer address for the next conversion |
| bus_in | input | DW | Converter data bus |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Output sample accepted |
| smp_data | output | DW | Captured sample |
| smp_chan | output | CW | Channel the sample was converted from |
| timeout_err | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
The properties assume that `eoc_n` is synchronous to `clk`. They also assume that `eoc_n` is asserted only after `conv_n` has been low for its full pulse and is released once `cs_n` falls, and that `pd_mode` changes only under reset. The bench meets these assumptions with a converter model. Its conversion delay is longer than the start pulse, it drops the end-of-conversion indication as soon as chip select goes low, and it changes mode and mask only between resets. A silent-converter phase exercises the timeout.

// File: rtl/mux_adc_seq_pkg.sv
package mux_adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WAIT, S_SETUP, S_READ, S_HOLD, S_GAP
  } seq_state_t;
endpackage

// File: rtl/mux_adc_seq_next.sv
// Finds the next enabled channel above cur, wrapping; returns cur if none.
module mux_adc_seq_next #(
  parameter int NUM_CH = 8,
  parameter int CW     = 3
) (
  input  logic [CW-1:0]     cur,
  input  logic [NUM_CH-1:0] mask,
  output logic [CW-1:0]     nxt
);
  always_comb begin
    logic found;
    found = 1'b0;
    nxt   = cur;
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (int'(cur) + k) % NUM_CH;
      if (!found && mask[idx]) begin
        nxt   = CW'(idx);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mux_adc_seq_period.sv
// Saturating cycles-since-start counter; reached is high once LIMIT-1 is hit.
module mux_adc_seq_period #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic reached
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= TOP;
    else if (clear)       cnt <= '0;
    else if (cnt != TOP)  cnt <= cnt + 1'b1;
  end

  assign reached = (cnt == TOP);
endmodule

// File: rtl/mux_adc_sequencer.sv
module mux_adc_sequencer #(
  parameter int DW             = 8,
  parameter int NUM_CH         = 8,
  parameter int CONV_LOW_CYC   = 3,
  parameter int SETUP_CYC      = 2,
  parameter int READ_CYC       = 2,
  parameter int TIMEOUT_CYC    = 1000,
  parameter int MIN_PERIOD_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic              pd_mode,
  output logic              conv_n,
  input  logic              eoc_n,
  output logic              cs_n,
  output logic              rd_n,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] addr,
  input  logic [DW-1:0]     bus_in,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DW-1:0]     smp_data,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] smp_chan,
  output logic              timeout_err
);
  import mux_adc_seq_pkg::*;

  localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int MAX_A = (CONV_LOW_CYC > SETUP_CYC) ? CONV_LOW_CYC : SETUP_CYC;
  localparam int MAX_B = (READ_CYC > TIMEOUT_CYC) ? READ_CYC : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1);

  localparam logic [CNT_W-1:0] LOW_END   = CNT_W'(CONV_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] READ_END  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] TO_END    = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    cur_ch;
  logic [CW-1:0]    nxt_ch;
  logic             go, period_ok, start_now;

  assign go        = enable && (|chan_mask);
  assign start_now = go && ((state == S_IDLE) || (state == S_GAP && period_ok));

  mux_adc_seq_next #(.NUM_CH(NUM_CH), .CW(CW)) next_i (
    .cur (addr),
    .mask(chan_mask),
    .nxt (nxt_ch)
  );

  mux_adc_seq_period #(.LIMIT(MIN_PERIOD_CYC)) period_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_now),
    .reached(period_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt         <= '0;
      conv_n      <= 1'b1;
      cs_n        <= 1'b1;
      rd_n        <= 1'b1;
      addr        <= '0;
      cur_ch      <= '0;
      smp_valid   <= 1'b0;
      smp_data    <= '0;
      smp_chan    <= '0;
      timeout_err <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          addr   <= '0;
          cur_ch <= '0;
          cnt    <= '0;
          if (start_now) begin
            state  <= S_START;
            conv_n <= 1'b0;
          end
        end
        S_START: begin
          if (cnt == LOW_END) begin
            cnt    <= '0;
            state  <= S_WAIT;
            conv_n <= !pd_mode;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (!eoc_n) begin
            state  <= S_SETUP;
            conv_n <= 1'b1;
            cs_n   <= 1'b0;
            addr   <= nxt_ch;
            cnt    <= '0;
          end else if (cnt == TO_END) begin
            state       <= S_IDLE;
            conv_n      <= 1'b1;
            timeout_err <= 1'b1;
            cnt         <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SETUP: begin
          if (cnt == SETUP_END) begin
            rd_n  <= 1'b0;
            state <= S_READ;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READ: begin
          if (cnt == READ_END) begin
            rd_n      <= 1'b1;
            cs_n      <= 1'b1;
            smp_valid <= 1'b1;
            smp_data  <= bus_in;
            smp_chan  <= cur_ch;
            cur_ch    <= addr;
            state     <= S_HOLD;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (smp_ready) begin
            smp_valid <= 1'b0;
            state     <= S_GAP;
          end
        end
        S_GAP: begin
          if (period_ok) begin
            if (start_now) begin
              state  <= S_START;
              conv_n <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mux_adc_seq_chk.sv
module mux_adc_seq_chk #(
  parameter int CW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_n,
  input logic          eoc_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic [CW-1:0] addr,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [DW-1:0] smp_data,
  input logic [CW-1:0] smp_chan,
  input logic          pd_mode,
  input logic          timeout_err
);
  p_rd_inside_cs_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);

  p_addr_steady_read_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> $stable(addr));

  p_addr_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> $stable(addr) && !cs_n);

  p_hold_sample_r7: assert property (@(posedge clk) disable iff (rst)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(smp_chan));

  p_no_start_pending_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_n) |-> !smp_valid && cs_n);

  p_start_released_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> conv_n);

  p_awake_at_eoc_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_mode && !eoc_n && cs_n |-> conv_n);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);
endmodule

bind mux_adc_sequencer mux_adc_seq_chk #(.CW(CW), .DW(DW)) chk_i (.*);

// File: tb/mux_adc_sequencer_tb.sv
module mux_adc_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, NUM_CH = 8, CW = 3;
  localparam int CONV_LOW = 3, SETUP = 2, READ = 2, TIMEOUT = 40, MIN_PER = 20;
  localparam int CONV_DLY = 6;

  logic clk = 0, rst = 1, enable = 0, pd_mode = 0, smp_ready = 1;
  logic [NUM_CH-1:0] chan_mask = '0;
  logic eoc_n = 1;
  logic [DW-1:0] bus_in = '0;
  logic conv_n, cs_n, rd_n, smp_valid, timeout_err;
  logic [CW-1:0] addr, smp_chan;
  logic [DW-1:0] smp_data;

  mux_adc_sequencer #(.DW(DW), .NUM_CH(NUM_CH), .CONV_LOW_CYC(CONV_LOW),
    .SETUP_CYC(SETUP), .READ_CYC(READ), .TIMEOUT_CYC(TIMEOUT),
    .MIN_PERIOD_CYC(MIN_PER)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, acc_cnt = 0, falls = 0;
  bit mute = 0, bp = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int cur, input logic [NUM_CH-1:0] m);
    for (int k = 1; k <= NUM_CH; k++)
      if (m[(cur + k) % NUM_CH]) return (cur + k) % NUM_CH;
    return cur;
  endfunction

  // behavioural reference model, evaluated on each rising edge
  int ms, mc, mper, e_addr, mcur, e_data, e_chan;
  bit e_cnv, e_cs, e_rd, e_val, e_err;
  int lat_data, lat_chan;
  int q[$];

  always @(posedge clk) begin
    bit go, st;
    cyc++;
    if (rst) begin
      ms = 0; mc = 0; mper = 0; e_addr = 0; mcur = 0; e_data = 0; e_chan = 0;
      e_cnv = 1; e_cs = 1; e_rd = 1; e_val = 0; e_err = 0;
    end else begin
      go = enable && (chan_mask != 0);
      st = 0;
      if (e_val && smp_ready) begin
        if (q.size() > 0) begin
          int ex;
          ex = q.pop_front();
          chk(lat_data == (ex & 255), "R5 accepted data", lat_data, ex & 255);
          chk(lat_chan == (ex >> 8), "R6 accepted channel", lat_chan, ex >> 8);
        end else chk(0, "R5 sample without conversion", lat_data, -1);
        acc_cnt++;
      end
      case (ms)
        0: begin e_addr = 0; mcur = 0; mc = 0; if (go) begin ms = 1; e_cnv = 0; st = 1; end end
        1: if (mc == CONV_LOW - 1) begin mc = 0; ms = 2; e_cnv = !pd_mode; end else mc++;
        2: if (!eoc_n) begin ms = 3; e_cnv = 1; e_cs = 0; e_addr = nxt(e_addr, chan_mask); mc = 0; end
           else if (mc == TIMEOUT - 1) begin ms = 0; e_cnv = 1; e_err = 1; mc = 0; end
           else mc++;
        3: if (mc == SETUP - 1) begin e_rd = 0; ms = 4; mc = 0; end else mc++;
        4: if (mc == READ - 1) begin
             e_rd = 1; e_cs = 1; e_val = 1; e_data = bus_in; e_chan = mcur; mcur = e_addr;
             ms = 5; mc = 0;
           end else mc++;
        5: if (smp_ready) begin e_val = 0; ms = 6; end
        default: if (mper >= MIN_PER - 1) begin
             if (go) begin ms = 1; e_cnv = 0; st = 1; end else ms = 0;
           end
      endcase
      mper = st ? 0 : mper + 1;
    end
  end

  // compare, monitors and converter model on falling edges
  bit prev_cnv = 1, prev_rd = 1, busy = 0;
  int cd, cch, mux, seqn, ech, last_fall;
  logic [CW-1:0] prev_addr;

  always @(negedge clk) begin
    chk(conv_n == e_cnv, "R2/R3 conv_n", conv_n, e_cnv);
    chk(cs_n == e_cs, "R4 cs_n", cs_n, e_cs);
    chk(rd_n == e_rd, "R4 rd_n", rd_n, e_rd);
    chk(addr == e_addr, "R6 addr", addr, e_addr);
    chk(smp_valid == e_val, "R7 smp_valid", smp_valid, e_val);
    chk(timeout_err == e_err, "R9 timeout_err", timeout_err, e_err);
    if (e_val) begin
      chk(smp_data == e_data, "R5 smp_data", smp_data, e_data);
      chk(smp_chan == e_chan, "R5 smp_chan", smp_chan, e_chan);
    end
    lat_data = smp_data; lat_chan = smp_chan;
    if (!rd_n) chk(!cs_n, "R11 rd inside cs", cs_n, 0);
    if (rst) begin
      busy = 0; eoc_n = 1; mux = 0; seqn = 0; ech = 0; last_fall = -1000; q.delete();
    end else begin
      if (prev_cnv && !conv_n) begin
        falls++;
        chk(cyc - last_fall >= MIN_PER, "R8 start spacing", cyc - last_fall, MIN_PER);
        chk(!smp_valid, "R7 no start while pending", smp_valid, 0);
        chk(mux == ech, "R6 converted channel", mux, ech);
        ech = nxt(ech, chan_mask);
        last_fall = cyc; busy = 1; cd = CONV_DLY; cch = mux;
      end else if (busy) begin
        cd--;
        if (cd == 0) begin
          busy = 0;
          if (!mute) begin
            eoc_n = 0;
            bus_in = DW'((cch << 5) | (seqn & 31));
            q.push_back((cch << 8) | int'(bus_in));
            seqn++;
          end
        end
      end
      if (!cs_n) eoc_n = 1;
      if (prev_rd && !rd_n) begin
        chk(addr == prev_addr, "R11 addr stable at read", addr, prev_addr);
        mux = addr;
      end
    end
    prev_cnv = conv_n; prev_rd = rd_n; prev_addr = addr;
  end

  // ready pattern, changed away from both edges
  always @(posedge clk) begin
    #2 smp_ready = bp ? ((cyc % 5) >= 3) : 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset;
    @(posedge clk); #2 rst = 1; enable = 0;
    step(3);
    rst = 0;
  endtask

  task automatic run_samples(input int n);
    int target;
    target = acc_cnt + n;
    while (acc_cnt < target && !done) step(1);
  endtask

  initial begin
    int f0;
    step(3);
    // R1 reset state
    @(negedge clk);
    chk(conv_n && cs_n && rd_n, "R1 strobes high", {conv_n, cs_n, rd_n}, 7);
    chk(addr == 0 && !smp_valid && !timeout_err, "R1 idle outputs", addr, 0);
    do_reset;
    @(negedge clk);
    chk(conv_n && !smp_valid && addr == 0, "R1 after release", conv_n, 1);

    // normal mode, sparse mask
    chan_mask = 8'b1010_0110; pd_mode = 0; enable = 1;
    run_samples(12);
    chk(!timeout_err, "R9 no false timeout", timeout_err, 0);

    // backpressure
    do_reset; bp = 1; chan_mask = 8'hFF; enable = 1;
    run_samples(12);
    bp = 0;

    // power-down mode, wrap-around
    do_reset; pd_mode = 1; chan_mask = 8'h81; enable = 1;
    run_samples(10);

    // single channel above zero
    do_reset; pd_mode = 0; chan_mask = 8'h10; enable = 1;
    run_samples(6);

    // R10 idle conditions
    do_reset; chan_mask = 8'h00; enable = 1;
    f0 = falls; step(60);
    chk(falls == f0, "R10 zero mask idle", falls - f0, 0);
    chan_mask = 8'h0F; enable = 0;
    step(60);
    chk(falls == f0, "R10 disabled idle", falls - f0, 0);

    // R9 timeout
    do_reset; chan_mask = 8'h01; mute = 1; enable = 1;
    step(CONV_LOW + TIMEOUT + 5);
    @(negedge clk);
    chk(timeout_err, "R9 timeout flag", timeout_err, 1);
    enable = 0; mute = 0;
    step(30);
    @(negedge clk);
    chk(timeout_err && conv_n, "R9 sticky and released", {timeout_err, conv_n}, 3);
    do_reset;
    @(negedge clk);
    chk(!timeout_err, "R1 reset clears error", timeout_err, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule